// File: doc/BRIEF.md
# Reset Cause Recorder and Software Reset Pulser

This block gathers every reset request in a small system-on-chip and turns them into three reset outputs: a whole-chip reset, a reset for the processor core alone, and a reset for the DMA engine that stays on for as long as software asks. Four hardware sources request a whole-chip reset: the external reset pin, the watchdog, the low-voltage detector and the brown-out detector. The processor core's own system-reset request resets only the core. Software reaches the block over a simple register bus. It can fire a fixed-length chip or core reset pulse, and it can hold the DMA reset.

A cause register records which sources have fired. Only a true power-on clears it, so its flags survive the resets they describe. Flags pile up until software clears them by writing ones. The reset-control bits are guarded by an unlock key. Software must write three bytes in order to a key register before it can write them. Any whole-chip reset locks the key register again.

Top module: `rst_cause_ctrl`

## Requirements
- R1: After power-on (`por_n` low, then high) with no requests active, all three reset outputs are low. The cause register at offset 0x04 reads 0x01, the control register at offset 0x08 reads 0 and the key register at offset 0x100 reads 0.
- R2: While any of `pin_req`, `wdt_req`, `lvr_req` or `bod_req` is high, `chip_rst_o`, `cpu_rst_o` and `dma_rst_o` are all high in that same cycle. `sys_req` alone raises only `cpu_rst_o`.
- R3: A request that is high at a rising edge sets its cause flag, which reads back from the next cycle. The bits are: pin 1, watchdog 2, low-voltage 3, brown-out 4, core request 5. Flags accumulate, and no reset output clears them.
- R4: A write to offset 0x04 clears each flag whose data bit is 1 and leaves the others unchanged. If a hardware request sets a flag in the same cycle as that flag is cleared, the flag stays 1.
- R5: Key register bit 0 reads 1 after the bytes 0x59, 0x16, 0x88 are written to offset 0x100 one after another (data bits 7:0). A wrong byte starts the sequence again, and 0x59 counts as a new first byte. Any key write while unlocked locks it again.
- R6: While locked, a write to offset 0x08 has no effect: no pulse starts, and the DMA hold and the control readback are unchanged.
- R7: An unlocked write of 1 to control bit 0 raises `chip_rst_o` for exactly PULSE_CYCLES cycles, starting the cycle after the write. Control bit 0 reads 1 for those cycles and cause bit 0 is set. The chip reset clears the unlock state, the DMA hold and any core pulse.
- R8: An unlocked write of 1 to control bit 1 raises `cpu_rst_o` for exactly PULSE_CYCLES cycles without raising `chip_rst_o`, and sets cause bit 7. The block stays unlocked.
- R9: Control bit 2 is a level: `dma_rst_o` follows the value last written (unlocked) until software writes 0 or a chip reset clears it.
- R10: While `chip_rst_o` is high, writes to the control and key registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | True power-on reset, active low, asynchronous |
| pin_req | input | 1 | External reset pin request |
| wdt_req | input | 1 | Watchdog reset request |
| lvr_req | input | 1 | Low-voltage reset request |
| bod_req | input | 1 | Brown-out reset request |
| sys_req | input | 1 | Processor core system-reset request |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| chip_rst_o | output | 1 | Whole-chip reset |
| cpu_rst_o | output | 1 | Processor core reset |
| dma_rst_o | output | 1 | DMA engine reset |

## Verification
The three reset outputs respond in the same cycle to the hardware request inputs. Cause flags, control readback and the unlock bit change one clock after the edge that samples the triggering write or request. A software pulse is high from the first cycle after the write and stays high for PULSE_CYCLES cycles. The bench drives inputs 2 ns after each rising edge and compares every output and the read data against its model at the falling edge. Its directed checks read registers 1 ns after driving the address, so each result is sampled in the cycle it is due.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

  localparam int CAUSE_W = 8;

  // cause flag positions
  localparam int C_CHIP = 0;
  localparam int C_PIN  = 1;
  localparam int C_WDT  = 2;
  localparam int C_LVR  = 3;
  localparam int C_BOD  = 4;
  localparam int C_SYS  = 5;
  localparam int C_CPU  = 7;

  // control bit positions
  localparam int K_CHIP = 0;
  localparam int K_CPU  = 1;
  localparam int K_DMA  = 2;

  localparam logic [7:0] KEY_B0 = 8'h59;
  localparam logic [7:0] KEY_B1 = 8'h16;
  localparam logic [7:0] KEY_B2 = 8'h88;

  typedef enum logic [1:0] {KEY_IDLE, KEY_ONE, KEY_TWO} key_step_e;

  // sticky flags: clear-by-one, hardware set has priority
  function automatic logic [CAUSE_W-1:0] cause_update(
    input logic [CAUSE_W-1:0] cur,
    input logic [CAUSE_W-1:0] clr,
    input logic [CAUSE_W-1:0] set
  );
    return (cur & ~clr) | set;
  endfunction

  function automatic key_step_e key_advance(input key_step_e st, input logic [7:0] b);
    if (st == KEY_ONE && b == KEY_B1) return KEY_TWO;
    if (st == KEY_TWO && b == KEY_B2) return KEY_IDLE;
    if (b == KEY_B0) return KEY_ONE;
    return KEY_IDLE;
  endfunction

  function automatic logic key_completes(input key_step_e st, input logic [7:0] b);
    return (st == KEY_TWO) && (b == KEY_B2);
  endfunction

endpackage

// File: rtl/rstc_key_lock.sv
module rstc_key_lock
  import rstc_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       clear,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  output logic       unlocked
);

  key_step_e step_q;
  logic      open_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      step_q <= KEY_IDLE;
      open_q <= 1'b0;
    end else if (clear) begin
      step_q <= KEY_IDLE;
      open_q <= 1'b0;
    end else if (key_wr) begin
      if (open_q) begin
        open_q <= 1'b0;
        step_q <= (key_byte == KEY_B0) ? KEY_ONE : KEY_IDLE;
      end else begin
        step_q <= key_advance(step_q, key_byte);
        open_q <= key_completes(step_q, key_byte);
      end
    end
  end

  assign unlocked = open_q;

endmodule

// File: rtl/rstc_oneshot.sv
module rstc_oneshot #(
  parameter int PULSE_CYCLES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic clear,
  input  logic fire,
  output logic active
);

  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

  function automatic logic [CNT_W-1:0] count_down(input logic [CNT_W-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (fire)  cnt_q <= CNT_W'(PULSE_CYCLES);
    else            cnt_q <= count_down(cnt_q);
  end

  assign active = (cnt_q != '0);

endmodule

// File: rtl/rstc_cause_reg.sv
module rstc_cause_reg
  import rstc_pkg::*;
(
  input  logic               clk,
  input  logic               por_n,
  input  logic [CAUSE_W-1:0] set_vec,
  input  logic [CAUSE_W-1:0] clr_vec,
  output logic [CAUSE_W-1:0] cause
);

  logic [CAUSE_W-1:0] flags_q;

  // only power-on resets the flags; bit C_CHIP marks the power-on itself
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) flags_q <= CAUSE_W'(1) << C_CHIP;
    else        flags_q <= cause_update(flags_q, clr_vec, set_vec);
  end

  assign cause = flags_q;

endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rstc_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 32,
  parameter int PULSE_CYCLES = 2,
  parameter int OFS_CAUSE    = 'h004,
  parameter int OFS_CTRL     = 'h008,
  parameter int OFS_KEY      = 'h100
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              pin_req,
  input  logic              wdt_req,
  input  logic              lvr_req,
  input  logic              bod_req,
  input  logic              sys_req,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              chip_rst_o,
  output logic              cpu_rst_o,
  output logic              dma_rst_o
);

  localparam int N_SHOT = 2;
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_KEY   = ADDR_W'(OFS_KEY);

  // named internal events
  logic bus_wr, cause_wr, ctrl_wr_try, key_wr, ctrl_wr_ok;
  logic hw_chip_req;
  logic unlocked;
  logic sw_chip_go, sw_cpu_go;
  logic sw_chip_active, sw_cpu_active;
  logic dma_hold;
  logic [N_SHOT-1:0] shot_fire, shot_clear, shot_active;
  logic [CAUSE_W-1:0] cause_q, cause_set, cause_clr;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:8];

  // bus decode
  assign bus_wr      = bus_en & bus_we;
  assign cause_wr    = bus_wr & (bus_addr == A_CAUSE);
  assign ctrl_wr_try = bus_wr & (bus_addr == A_CTRL);
  assign key_wr      = bus_wr & (bus_addr == A_KEY) & ~chip_rst_o;
  assign ctrl_wr_ok  = ctrl_wr_try & unlocked & ~chip_rst_o;

  // reset merge
  assign hw_chip_req = pin_req | wdt_req | lvr_req | bod_req;
  assign chip_rst_o  = hw_chip_req | sw_chip_active;
  assign cpu_rst_o   = chip_rst_o | sys_req | sw_cpu_active;
  assign dma_rst_o   = chip_rst_o | dma_hold;

  // software pulse launches
  assign sw_chip_go = ctrl_wr_ok & bus_wdata[K_CHIP];
  assign sw_cpu_go  = ctrl_wr_ok & bus_wdata[K_CPU] & ~sw_cpu_active;

  // channel 0: chip pulse (never cut short), channel 1: core pulse (cut by chip reset)
  assign shot_fire  = {sw_cpu_go, sw_chip_go};
  assign shot_clear = {chip_rst_o, 1'b0};

  for (genvar g = 0; g < N_SHOT; g++) begin : g_shot
    rstc_oneshot #(.PULSE_CYCLES(PULSE_CYCLES)) i_shot (
      .clk    (clk),
      .por_n  (por_n),
      .clear  (shot_clear[g]),
      .fire   (shot_fire[g]),
      .active (shot_active[g])
    );
  end

  assign sw_chip_active = shot_active[0];
  assign sw_cpu_active  = shot_active[1];

  rstc_key_lock i_lock (
    .clk      (clk),
    .por_n    (por_n),
    .clear    (chip_rst_o),
    .key_wr   (key_wr),
    .key_byte (bus_wdata[7:0]),
    .unlocked (unlocked)
  );

  // DMA hold level
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          dma_hold <= 1'b0;
    else if (chip_rst_o) dma_hold <= 1'b0;
    else if (ctrl_wr_ok) dma_hold <= bus_wdata[K_DMA];
  end

  // cause flags
  always_comb begin
    cause_set         = '0;
    cause_set[C_CHIP] = sw_chip_go;
    cause_set[C_PIN]  = pin_req;
    cause_set[C_WDT]  = wdt_req;
    cause_set[C_LVR]  = lvr_req;
    cause_set[C_BOD]  = bod_req;
    cause_set[C_SYS]  = sys_req;
    cause_set[C_CPU]  = sw_cpu_go;
  end

  assign cause_clr = cause_wr ? bus_wdata[CAUSE_W-1:0] : '0;

  rstc_cause_reg i_cause (
    .clk     (clk),
    .por_n   (por_n),
    .set_vec (cause_set),
    .clr_vec (cause_clr),
    .cause   (cause_q)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CAUSE) begin
      bus_rdata[CAUSE_W-1:0] = cause_q;
    end else if (bus_addr == A_CTRL) begin
      bus_rdata[K_CHIP] = sw_chip_active;
      bus_rdata[K_CPU]  = sw_cpu_active;
      bus_rdata[K_DMA]  = dma_hold;
    end else if (bus_addr == A_KEY) begin
      bus_rdata[0] = unlocked;
    end
  end

endmodule

// File: rtl/rst_cause_ctrl_chk.sv
module rst_cause_ctrl_chk #(
  parameter int PULSE_CYCLES = 2
) (
  input logic       clk,
  input logic       por_n,
  input logic       pin_req,
  input logic       wdt_req,
  input logic       lvr_req,
  input logic       bod_req,
  input logic       sys_req,
  input logic       chip_rst_o,
  input logic       cpu_rst_o,
  input logic       dma_rst_o,
  input logic       unlocked,
  input logic       sw_chip_active,
  input logic       sw_cpu_active,
  input logic       dma_hold,
  input logic       ctrl_wr_try,
  input logic [7:0] cause_q
);

  int unsigned run_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)              run_q <= 0;
    else if (sw_chip_active) run_q <= run_q + 1;
    else                     run_q <= 0;
  end

  p_hw_merge_r2: assert property (@(posedge clk) disable iff (!por_n)
    (pin_req | wdt_req | lvr_req | bod_req) |-> (chip_rst_o && cpu_rst_o && dma_rst_o));

  p_sys_core_r2: assert property (@(posedge clk) disable iff (!por_n)
    sys_req |-> cpu_rst_o);

  p_flag_wdt_r3: assert property (@(posedge clk) disable iff (!por_n)
    wdt_req |=> cause_q[2]);

  p_flag_pin_r3: assert property (@(posedge clk) disable iff (!por_n)
    pin_req |=> cause_q[1]);

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!por_n)
    bod_req |=> cause_q[4]);

  p_locked_r6: assert property (@(posedge clk) disable iff (!por_n)
    (ctrl_wr_try && !unlocked && !chip_rst_o) |=>
      ($stable(dma_hold) && !$rose(sw_chip_active) && !$rose(sw_cpu_active)));

  p_pulse_short_r7: assert property (@(posedge clk) disable iff (!por_n)
    sw_chip_active |-> (run_q < PULSE_CYCLES));

  p_pulse_full_r7: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sw_chip_active) |-> (run_q == PULSE_CYCLES));

  p_chip_cause_r7: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sw_chip_active) |-> cause_q[0]);

  p_relock_r7: assert property (@(posedge clk) disable iff (!por_n)
    chip_rst_o |=> (!unlocked && !dma_hold));

  p_core_cause_r8: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sw_cpu_active) |-> cause_q[7]);

  p_dma_level_r9: assert property (@(posedge clk) disable iff (!por_n)
    dma_hold |-> dma_rst_o);

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!por_n)
    (ctrl_wr_try && chip_rst_o) |=> (!$rose(sw_cpu_active) && !dma_hold));

endmodule

bind rst_cause_ctrl rst_cause_ctrl_chk #(.PULSE_CYCLES(PULSE_CYCLES)) i_chk (
  .clk            (clk),
  .por_n          (por_n),
  .pin_req        (pin_req),
  .wdt_req        (wdt_req),
  .lvr_req        (lvr_req),
  .bod_req        (bod_req),
  .sys_req        (sys_req),
  .chip_rst_o     (chip_rst_o),
  .cpu_rst_o      (cpu_rst_o),
  .dma_rst_o      (dma_rst_o),
  .unlocked       (unlocked),
  .sw_chip_active (sw_chip_active),
  .sw_cpu_active  (sw_cpu_active),
  .dma_hold       (dma_hold),
  .ctrl_wr_try    (ctrl_wr_try),
  .cause_q        (cause_q)
);

// File: tb/test_rst_cause_ctrl.sv
module test_rst_cause_ctrl;

  localparam int PULSE = 2;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        pin_req = 0, wdt_req = 0, lvr_req = 0, bod_req = 0, sys_req = 0;
  logic        bus_en = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        chip_rst_o, cpu_rst_o, dma_rst_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rst_cause_ctrl #(.ADDR_W(12), .DATA_W(32), .PULSE_CYCLES(PULSE)) i_rst_cause_ctrl (
    .clk(clk), .por_n(por_n),
    .pin_req(pin_req), .wdt_req(wdt_req), .lvr_req(lvr_req), .bod_req(bod_req), .sys_req(sys_req),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .chip_rst_o(chip_rst_o), .cpu_rst_o(cpu_rst_o), .dma_rst_o(dma_rst_o)
  );

  // behavioural reference model
  int m_cause, m_chip, m_cpu, m_dma, m_unl, m_step;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_cause = 1; m_chip = 0; m_cpu = 0; m_dma = 0; m_unl = 0; m_step = 0;
    end else begin
      bit hw, busy, wr, cw, cgo, ugo;
      int setm, clrm;
      int b;
      hw   = pin_req | wdt_req | lvr_req | bod_req;
      busy = hw || (m_chip > 0);
      wr   = bus_en && bus_we;
      cw   = wr && bus_addr == 12'h008 && m_unl != 0 && !busy;
      cgo  = cw && bus_wdata[0];
      ugo  = cw && bus_wdata[1] && m_cpu == 0;
      setm = (cgo ? 1 : 0) + (pin_req ? 2 : 0) + (wdt_req ? 4 : 0) + (lvr_req ? 8 : 0)
           + (bod_req ? 16 : 0) + (sys_req ? 32 : 0) + (ugo ? 128 : 0);
      clrm = (wr && bus_addr == 12'h004) ? int'(bus_wdata[7:0]) : 0;
      m_cause = (m_cause & ~clrm & 255) | setm;
      if (cgo) m_chip = PULSE; else if (m_chip > 0) m_chip--;
      if (busy) begin
        m_unl = 0; m_step = 0; m_dma = 0; m_cpu = 0;
      end else begin
        if (ugo) m_cpu = PULSE; else if (m_cpu > 0) m_cpu--;
        if (cw) m_dma = bus_wdata[2] ? 1 : 0;
        if (wr && bus_addr == 12'h100) begin
          b = int'(bus_wdata[7:0]);
          if (m_unl != 0) begin m_unl = 0; m_step = (b == 'h59) ? 1 : 0; end
          else if (m_step == 2 && b == 'h88) begin m_unl = 1; m_step = 0; end
          else if (m_step == 1 && b == 'h16) m_step = 2;
          else m_step = (b == 'h59) ? 1 : 0;
        end
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    if (a == 12'h004) return 32'(m_cause);
    if (a == 12'h008) return 32'((m_dma << 2) | ((m_cpu > 0) ? 2 : 0) | ((m_chip > 0) ? 1 : 0));
    if (a == 12'h100) return 32'(m_unl);
    return 32'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (por_n && !done) begin
      logic e_chip;
      e_chip = pin_req | wdt_req | lvr_req | bod_req | (m_chip > 0);
      check("R7 chip_rst_o model", 32'(chip_rst_o), 32'(e_chip));
      check("R8 cpu_rst_o model", 32'(cpu_rst_o), 32'(e_chip | sys_req | (m_cpu > 0)));
      check("R9 dma_rst_o model", 32'(dma_rst_o), 32'(e_chip | (m_dma != 0)));
      check("R3 bus_rdata model", bus_rdata, exp_rd(bus_addr));
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    step();
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic unlock();
    wr(12'h100, 32'h59); wr(12'h100, 32'h16); wr(12'h100, 32'h88);
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      finish_up();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #2 por_n = 1'b1;
    step();

    // R1 reset state
    rd(12'h004, d); check("R1 cause after power-on", d, 32'h01);
    rd(12'h008, d); check("R1 control after power-on", d, 32'h0);
    rd(12'h100, d); check("R1 key after power-on", d, 32'h0);
    check("R1 outputs idle", {29'd0, chip_rst_o, cpu_rst_o, dma_rst_o}, 32'h0);

    // R4 clear power-on flag
    wr(12'h004, 32'h01);
    rd(12'h004, d); check("R4 clear power-on flag", d, 32'h0);

    // R2 / R3 watchdog request
    wdt_req = 1; #1;
    check("R2 watchdog merges to all", {29'd0, chip_rst_o, cpu_rst_o, dma_rst_o}, 32'h7);
    step(); wdt_req = 0;
    rd(12'h004, d); check("R3 watchdog flag", d, 32'h04);

    // R3 accumulate pin + low-voltage
    pin_req = 1; lvr_req = 1; step(); pin_req = 0; lvr_req = 0;
    rd(12'h004, d); check("R3 flags accumulate", d, 32'h0E);

    // R4 set wins over clear, partial clear
    bod_req = 1; wr(12'h004, 32'h1A); bod_req = 0;
    rd(12'h004, d); check("R4 set wins and partial clear", d, 32'h14);

    // R6 locked writes ignored
    wr(12'h008, 32'h4);
    rd(12'h008, d); check("R6 locked control write", d, 32'h0);
    check("R6 locked dma", 32'(dma_rst_o), 32'h0);
    wr(12'h008, 32'h1);
    check("R6 locked chip pulse", 32'(chip_rst_o), 32'h0);
    rd(12'h004, d); check("R6 cause unchanged", d, 32'h14);

    // R5 unlock sequence
    wr(12'h100, 32'h59); wr(12'h100, 32'h17); wr(12'h100, 32'h88);
    rd(12'h100, d); check("R5 wrong middle byte", d, 32'h0);
    wr(12'h100, 32'h59); wr(12'h100, 32'h59); wr(12'h100, 32'h16);
    rd(12'h100, d); check("R5 partial sequence", d, 32'h0);
    wr(12'h100, 32'h88);
    rd(12'h100, d); check("R5 restart then unlock", d, 32'h1);
    wr(12'h100, 32'h00);
    rd(12'h100, d); check("R5 key write relocks", d, 32'h0);
    unlock();

    // R9 dma hold
    wr(12'h008, 32'h4);
    check("R9 dma held", {30'd0, chip_rst_o, dma_rst_o}, 32'h1);
    repeat (3) step();
    check("R9 dma still held", 32'(dma_rst_o), 32'h1);
    wr(12'h008, 32'h0);
    check("R9 dma released", 32'(dma_rst_o), 32'h0);

    // R8 core pulse
    wr(12'h008, 32'h2);
    for (int i = 0; i < PULSE; i++) begin
      check("R8 core pulse high", {30'd0, chip_rst_o, cpu_rst_o}, 32'h1);
      step();
    end
    check("R8 core pulse ended", 32'(cpu_rst_o), 32'h0);
    rd(12'h004, d); check("R8 core cause flag", d, 32'h94);
    rd(12'h100, d); check("R8 stays unlocked", d, 32'h1);

    // R2 core request alone
    sys_req = 1; #1;
    check("R2 core request only", {29'd0, chip_rst_o, cpu_rst_o, dma_rst_o}, 32'h2);
    step(); sys_req = 0;
    rd(12'h004, d); check("R3 core request flag", d, 32'hB4);

    // R7 chip pulse with dma hold
    wr(12'h008, 32'h5);
    for (int i = 0; i < PULSE; i++) begin
      check("R7 chip pulse high", 32'(chip_rst_o), 32'h1);
      rd(12'h008, d); check("R7 control bit 0 reads 1", d & 32'h1, 32'h1);
      step();
    end
    check("R7 chip pulse ended", {29'd0, chip_rst_o, cpu_rst_o, dma_rst_o}, 32'h0);
    rd(12'h100, d); check("R7 relocked", d, 32'h0);
    rd(12'h008, d); check("R7 dma hold cleared", d, 32'h0);
    rd(12'h004, d); check("R3 flags survive chip reset", d, 32'hB5);

    // R10 writes ignored during chip reset
    unlock();
    wdt_req = 1; wr(12'h008, 32'h6); wdt_req = 0;
    #1;
    check("R10 no core pulse", 32'(cpu_rst_o), 32'h0);
    check("R10 no dma hold", 32'(dma_rst_o), 32'h0);
    rd(12'h008, d); check("R10 control unchanged", d, 32'h0);
    rd(12'h100, d); check("R10 relocked by request", d, 32'h0);
    step();

    done = 1;
    finish_up();
  end

endmodule